// File: doc/BRIEF.md
# Host-to-Coprocessor Mailbox Bridge

This block sits between a host processor with an 8-bit data bus and a 32-bit coprocessor. For the coprocessor it is the address decoder: every byte address falls in a 128 KiB program ROM window at address zero, a 16 KiB RAM window at 0xE0000000, a 16-byte mailbox window at 0x40000020, or in unmapped space. The ROM and RAM arrays live outside the block and are reached through four byte-lane ports with one cycle of read latency. For the host it presents the same mailbox bytes at three 16-bit offsets.

The block holds two groups of four bytes. The host-to-coprocessor group is written by the host and read by the coprocessor. The coprocessor-to-host group is written by the coprocessor and read by the host. The two sides index these bytes differently, and the host reaches only some of them.

A coprocessor access of any size is always handled as four byte lanes at addr+0 to addr+3, decoded one by one and assembled little-endian. Narrow writes read the existing word first, replace its low byte or halfword, and then write all four lanes back.

Top module: `mailbox_bridge`

## Requirements
- R1: After reset all eight mailbox bytes are 0x00, `host_rdata` is 0x00 and `cp_done` is low.
- R2: A host read strobe returns data on `host_rdata` in the next cycle. Only the low 16 bits of `host_addr` are decoded. Offset 0x3800 returns coprocessor-to-host byte 0, 0x3802 returns byte 1, and 0x3804 returns byte 3.
- R3: A host read at any other offset returns 0x00. This includes odd offsets and 0x3806.
- R4: A host write at offset 0x3802 stores host-to-coprocessor byte 1, and a host write at 0x3804 stores byte 0. Host writes at any other offset change nothing.
- R5: A coprocessor byte lane at address 0x40000020 + 4k (k = 0..3) reads host-to-coprocessor byte k. Lanes at other addresses inside the mailbox window read 0x00.
- R6: A coprocessor write lane at 0x40000020 + 4k sets coprocessor-to-host byte k. Write lanes at other addresses in the window are ignored.
- R7: A request on `cp_valid` raises `cp_done` in the next cycle, and no other cycle. Read data appear on `cp_rdata` in that same cycle, with the byte from addr+i in bits 8i+7..8i. ROM lanes cover 0x00000000 to 0x0001FFFF.
- R8: RAM lanes cover 0xE0000000 to 0xE0003FFF. Data written there are read back unchanged.
- R9: `cp_size` uses the codes 0 = byte, 1 = halfword, 2 = word. Byte and halfword reads return the assembled word masked to its low 8 or 16 bits.
- R10: A byte or halfword write keeps the upper 24 or 16 bits of the existing four-lane word. It replaces the low bits with `cp_wdata` and writes all four lanes.
- R11: Unmapped lanes read 0x00. Write lanes to ROM, unmapped space or non-port mailbox addresses change no RAM byte and no mailbox byte.
- R12: A host write and a coprocessor read of the same host-to-coprocessor byte in one cycle return the old value to the coprocessor. A host read in the cycle a coprocessor mailbox write commits (its `cp_done` cycle) returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host access strobe, one cycle |
| host_write | input | 1 | 1 = host write, 0 = host read |
| host_addr | input | HOST_AW | Host address, low 16 bits decoded |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid the cycle after the strobe |
| cp_valid | input | 1 | Coprocessor access strobe, one cycle |
| cp_write | input | 1 | 1 = coprocessor write |
| cp_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cp_addr | input | 32 | Coprocessor byte address |
| cp_wdata | input | 32 | Coprocessor write data |
| cp_rdata | output | 32 | Coprocessor read data during `cp_done` |
| cp_done | output | 1 | Access completes this cycle |
| rom_addr | output | 4 x ROM_AW | ROM byte address per lane |
| rom_rdata | input | 4 x 8 | ROM byte per lane, one cycle after address |
| ram_addr | output | 4 x RAM_AW | RAM read address per lane |
| ram_rdata | input | 4 x 8 | RAM byte per lane, one cycle after address |
| ram_we | output | 4 | RAM write enable per lane |
| ram_waddr | output | 4 x RAM_AW | RAM write address per lane |
| ram_wdata | output | 4 x 8 | RAM write byte per lane |

## Verification
The bench targets the places where one lane of an access lands in a different region than its neighbours. These are a word read that runs off the end of ROM, a word read that ends on the first mailbox port, and a halfword write whose second lane hits a port while its first lane does not. A design that decoded only the base address would return ROM or port data in the wrong lanes here, or would write the wrong byte. The bench also checks the cross-wired host offsets and the port that the host cannot see. A swapped or symmetric index map shows up as a wrong byte at 0x3804 or a non-zero 0x3806. Narrow writes are checked against hand-computed merges, so a design that zeroed the upper lanes would break the RAM read-back. The two same-cycle collisions catch forwarding of new data where the old value is required.

// File: rtl/mailbox_bridge.sv
module mailbox_bridge #(
  parameter int          ROM_AW    = 17,
  parameter int          RAM_AW    = 14,
  parameter int          HOST_AW   = 24,
  parameter logic [31:0] RAM_BASE  = 32'hE000_0000,
  parameter logic [31:0] MBOX_BASE = 32'h4000_0020,
  parameter logic [15:0] HOST_BASE = 16'h3800
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_valid,
  input  logic                   host_write,
  input  logic [HOST_AW-1:0]     host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  input  logic                   cp_valid,
  input  logic                   cp_write,
  input  logic [1:0]             cp_size,
  input  logic [31:0]            cp_addr,
  input  logic [31:0]            cp_wdata,
  output logic [31:0]            cp_rdata,
  output logic                   cp_done,
  output logic [3:0][ROM_AW-1:0] rom_addr,
  input  logic [3:0][7:0]        rom_rdata,
  output logic [3:0][RAM_AW-1:0] ram_addr,
  input  logic [3:0][7:0]        ram_rdata,
  output logic [3:0]             ram_we,
  output logic [3:0][RAM_AW-1:0] ram_waddr,
  output logic [3:0][7:0]        ram_wdata
);
  localparam int          LANES   = 4;
  localparam logic [31:0] RAM_TAG = RAM_BASE >> RAM_AW;
  localparam logic [27:0] MBX_TAG = MBOX_BASE[31:4];
  localparam logic [15:0] HOFF_P0 = HOST_BASE;
  localparam logic [15:0] HOFF_P1 = 16'(HOST_BASE + 16'd2);
  localparam logic [15:0] HOFF_P3 = 16'(HOST_BASE + 16'd4);
  localparam logic [1:0]  SZ_BYTE = 2'd0;
  localparam logic [1:0]  SZ_HALF = 2'd1;

  typedef enum logic [1:0] {RG_NONE, RG_ROM, RG_RAM, RG_MBX} region_t;

  logic [LANES-1:0][7:0] h2c, c2h;
  region_t [LANES-1:0]   rgn, s1_rgn;
  logic [LANES-1:0][1:0] idx, s1_idx;
  logic [LANES-1:0][7:0] s1_mbx, old_lane, merged;
  logic [LANES-1:0][RAM_AW-1:0] s1_ram;
  logic        s1_valid, s1_write;
  logic [1:0]  s1_size;
  logic [31:0] s1_wdata, old_word;
  logic [15:0] hoff;
  logic        unused_host_hi;

  assign hoff           = host_addr[15:0];
  assign unused_host_hi = ^host_addr[HOST_AW-1:16];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [31:0] a;
    assign a           = cp_addr + 32'(i);
    assign rom_addr[i] = a[ROM_AW-1:0];
    assign ram_addr[i] = a[RAM_AW-1:0];
    assign idx[i]      = a[3:2];
    assign rgn[i] = ((a >> ROM_AW) == 32'd0)                   ? RG_ROM :
                    ((a >> RAM_AW) == RAM_TAG)                 ? RG_RAM :
                    (a[31:4] == MBX_TAG && a[1:0] == 2'b00)    ? RG_MBX : RG_NONE;

    always_comb begin
      case (s1_rgn[i])
        RG_ROM:  old_lane[i] = rom_rdata[i];
        RG_RAM:  old_lane[i] = ram_rdata[i];
        RG_MBX:  old_lane[i] = s1_mbx[i];
        default: old_lane[i] = 8'h00;
      endcase
    end

    assign ram_we[i]    = s1_valid && s1_write && (s1_rgn[i] == RG_RAM);
    assign ram_waddr[i] = s1_ram[i];
    assign ram_wdata[i] = merged[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_write <= 1'b0;
      s1_size  <= SZ_BYTE;
      s1_wdata <= '0;
      s1_rgn   <= {LANES{RG_NONE}};
      s1_idx   <= '0;
      s1_mbx   <= '0;
      s1_ram   <= '0;
    end else begin
      s1_valid <= cp_valid;
      if (cp_valid) begin
        s1_write <= cp_write;
        s1_size  <= cp_size;
        s1_wdata <= cp_wdata;
        s1_rgn   <= rgn;
        s1_idx   <= idx;
        s1_ram   <= ram_addr;
        for (int i = 0; i < LANES; i++) s1_mbx[i] <= h2c[idx[i]];
      end
    end
  end

  assign old_word = old_lane;

  always_comb begin
    case (s1_size)
      SZ_BYTE: merged = {old_word[31:8],  s1_wdata[7:0]};
      SZ_HALF: merged = {old_word[31:16], s1_wdata[15:0]};
      default: merged = s1_wdata;
    endcase
  end

  always_comb begin
    cp_rdata = 32'h0;
    if (s1_valid && !s1_write) begin
      case (s1_size)
        SZ_BYTE: cp_rdata = {24'h0, old_word[7:0]};
        SZ_HALF: cp_rdata = {16'h0, old_word[15:0]};
        default: cp_rdata = old_word;
      endcase
    end
  end

  assign cp_done = s1_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      h2c        <= '0;
      c2h        <= '0;
      host_rdata <= 8'h00;
    end else begin
      if (host_valid && host_write) begin
        if (hoff == HOFF_P1) h2c[1] <= host_wdata;
        if (hoff == HOFF_P3) h2c[0] <= host_wdata;
      end
      if (host_valid && !host_write) begin
        case (hoff)
          HOFF_P0: host_rdata <= c2h[0];
          HOFF_P1: host_rdata <= c2h[1];
          HOFF_P3: host_rdata <= c2h[3];
          default: host_rdata <= 8'h00;
        endcase
      end
      for (int i = 0; i < LANES; i++)
        if (s1_valid && s1_write && s1_rgn[i] == RG_MBX) c2h[s1_idx[i]] <= merged[i];
    end
  end

  assert_mbox_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (h2c == '0 && c2h == '0));

  assert_done_next_R7: assert property (@(posedge clk) disable iff (rst)
    cp_valid |=> cp_done);

  assert_host_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
    host_valid && !host_write && hoff != HOFF_P0 && hoff != HOFF_P1 && hoff != HOFF_P3
    |=> host_rdata == 8'h00);

  assert_host_port0_write_R4: assert property (@(posedge clk) disable iff (rst)
    host_valid && host_write && hoff == HOFF_P3 |=> h2c[0] == $past(host_wdata));

  assert_byte_read_masked_R9: assert property (@(posedge clk) disable iff (rst)
    cp_valid && !cp_write && cp_size == SZ_BYTE |=> cp_rdata[31:8] == 24'h0);

  assert_read_no_ram_write_R11: assert property (@(posedge clk) disable iff (rst)
    cp_valid && !cp_write |=> ram_we == 4'b0000);

endmodule

// File: tb/mailbox_bridge_bench.sv
module mailbox_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] OP_CRD = 2'd0, OP_CWR = 2'd1, OP_HRD = 2'd2, OP_HWR = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  size;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 47;
  localparam vec_t VEC [NVEC] = '{
    '{OP_CRD, 2'd2, 32'h0000_0100, 32'h0, 32'h0203_0001, 8'd7},  // R7 ROM word
    '{OP_CRD, 2'd2, 32'h0001_FFFE, 32'h0, 32'h0000_0100, 8'd7},  // R7 crosses ROM end
    '{OP_CRD, 2'd0, 32'h0000_0203, 32'h0, 32'h0000_0001, 8'd9},  // R9 byte mask
    '{OP_CRD, 2'd1, 32'h0000_0345, 32'h0, 32'h0000_4546, 8'd9},  // R9 half mask
    '{OP_CWR, 2'd2, 32'hE000_0010, 32'hA1B2_C3D4, 32'h0, 8'd8},  // R8
    '{OP_CRD, 2'd2, 32'hE000_0010, 32'h0, 32'hA1B2_C3D4, 8'd8},  // R8
    '{OP_CWR, 2'd1, 32'hE000_0010, 32'hFFFF_1234, 32'h0, 8'd10}, // R10 half merge
    '{OP_CRD, 2'd2, 32'hE000_0010, 32'h0, 32'hA1B2_1234, 8'd10}, // R10
    '{OP_CWR, 2'd0, 32'hE000_0013, 32'h0000_0077, 32'h0, 8'd10}, // R10 byte merge
    '{OP_CRD, 2'd2, 32'hE000_0010, 32'h0, 32'h77B2_1234, 8'd10}, // R10
    '{OP_CRD, 2'd0, 32'hE000_0012, 32'h0, 32'h0000_00B2, 8'd9},  // R9
    '{OP_CWR, 2'd2, 32'h0000_0010, 32'hDEAD_BEEF, 32'h0, 8'd11}, // R11 ROM write
    '{OP_CWR, 2'd2, 32'h8000_0010, 32'hDEAD_BEEF, 32'h0, 8'd11}, // R11 unmapped
    '{OP_CWR, 2'd2, 32'hE000_4010, 32'hDEAD_BEEF, 32'h0, 8'd11}, // R11 past RAM
    '{OP_CRD, 2'd2, 32'hE000_0010, 32'h0, 32'h77B2_1234, 8'd11}, // R11 RAM intact
    '{OP_CRD, 2'd2, 32'h8000_0000, 32'h0, 32'h0000_0000, 8'd11}, // R11
    '{OP_CRD, 2'd2, 32'hE000_4010, 32'h0, 32'h0000_0000, 8'd11}, // R11
    '{OP_HWR, 2'd0, 32'h0000_3804, 32'h5C, 32'h0, 8'd4},         // R4
    '{OP_HWR, 2'd0, 32'h0000_3802, 32'h6D, 32'h0, 8'd4},         // R4
    '{OP_HWR, 2'd0, 32'h0000_3800, 32'h99, 32'h0, 8'd4},         // R4 ignored
    '{OP_HWR, 2'd0, 32'h0000_3806, 32'hAB, 32'h0, 8'd4},         // R4 ignored
    '{OP_CRD, 2'd0, 32'h4000_0020, 32'h0, 32'h0000_005C, 8'd5},  // R5
    '{OP_CRD, 2'd0, 32'h4000_0024, 32'h0, 32'h0000_006D, 8'd5},  // R5
    '{OP_CRD, 2'd0, 32'h4000_0028, 32'h0, 32'h0000_0000, 8'd4},  // R4 no stray write
    '{OP_CRD, 2'd0, 32'h4000_002C, 32'h0, 32'h0000_0000, 8'd4},  // R4 no stray write
    '{OP_CRD, 2'd2, 32'h4000_0020, 32'h0, 32'h0000_005C, 8'd5},  // R5 lanes 1-3 zero
    '{OP_CRD, 2'd2, 32'h4000_001D, 32'h0, 32'h5C00_0000, 8'd5},  // R5 lane 3 on port
    '{OP_CWR, 2'd0, 32'h4000_0020, 32'h11, 32'h0, 8'd6},         // R6
    '{OP_CWR, 2'd0, 32'h4000_0024, 32'h22, 32'h0, 8'd6},         // R6
    '{OP_CWR, 2'd0, 32'h4000_0028, 32'h33, 32'h0, 8'd6},         // R6
    '{OP_CWR, 2'd0, 32'h4000_002C, 32'h44, 32'h0, 8'd6},         // R6
    '{OP_HRD, 2'd0, 32'h0000_3800, 32'h0, 32'h11, 8'd2},         // R2
    '{OP_HRD, 2'd0, 32'h0000_3802, 32'h0, 32'h22, 8'd2},         // R2
    '{OP_HRD, 2'd0, 32'h0000_3804, 32'h0, 32'h44, 8'd2},         // R2 byte 3
    '{OP_HRD, 2'd0, 32'h0000_3806, 32'h0, 32'h00, 8'd3},         // R3
    '{OP_HRD, 2'd0, 32'h0000_3801, 32'h0, 32'h00, 8'd3},         // R3
    '{OP_HRD, 2'd0, 32'h00AB_3802, 32'h0, 32'h22, 8'd2},         // R2 upper bits
    '{OP_CWR, 2'd2, 32'h4000_0020, 32'h1234_5678, 32'h0, 8'd6},  // R6 word to port
    '{OP_HRD, 2'd0, 32'h0000_3800, 32'h0, 32'h78, 8'd6},         // R6
    '{OP_HRD, 2'd0, 32'h0000_3802, 32'h0, 32'h22, 8'd6},         // R6
    '{OP_CWR, 2'd1, 32'h4000_0023, 32'hAAAA_5566, 32'h0, 8'd10}, // R10 lane 1 port
    '{OP_HRD, 2'd0, 32'h0000_3802, 32'h0, 32'h55, 8'd10},        // R10
    '{OP_CWR, 2'd0, 32'h4000_0021, 32'hEE, 32'h0, 8'd11},        // R11 non-port
    '{OP_HRD, 2'd0, 32'h0000_3800, 32'h0, 32'h78, 8'd11},        // R11
    '{OP_CRD, 2'd0, 32'h4000_0024, 32'h0, 32'h0000_006D, 8'd5},  // R5 untouched
    '{OP_HWR, 2'd0, 32'h00FF_3804, 32'h5D, 32'h0, 8'd2},         // R2 upper bits
    '{OP_CRD, 2'd0, 32'h4000_0020, 32'h0, 32'h0000_005D, 8'd2}   // R2
  };

  logic clk = 1'b0, rst = 1'b1;
  logic host_valid = 1'b0, host_write = 1'b0;
  logic [23:0] host_addr = '0;
  logic [7:0]  host_wdata = '0, host_rdata;
  logic cp_valid = 1'b0, cp_write = 1'b0;
  logic [1:0]  cp_size = '0;
  logic [31:0] cp_addr = '0, cp_wdata = '0, cp_rdata;
  logic        cp_done;
  logic [3:0][16:0] rom_addr;
  logic [3:0][7:0]  rom_rdata, ram_rdata, ram_wdata;
  logic [3:0][13:0] ram_addr, ram_waddr;
  logic [3:0]       ram_we;
  logic [7:0] ram_m [int unsigned];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mailbox_bridge u_mailbox_bridge (
    .clk(clk), .rst(rst),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cp_valid(cp_valid), .cp_write(cp_write), .cp_size(cp_size), .cp_addr(cp_addr),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_done(cp_done),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
  );

  function automatic logic [7:0] rom_fn(input logic [16:0] a);
    return a[7:0] ^ a[15:8] ^ {7'b0, a[16]};
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 4; i++) begin
      rom_rdata[i] <= rom_fn(rom_addr[i]);
      ram_rdata[i] <= ram_m.exists(32'(ram_addr[i])) ? ram_m[32'(ram_addr[i])] : 8'h00;
    end
    for (int i = 0; i < 4; i++)
      if (ram_we[i]) ram_m[32'(ram_waddr[i])] = ram_wdata[i];
  end

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cp_op(input logic wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic dn);
    @(negedge clk);
    cp_valid = 1'b1; cp_write = wr; cp_size = sz; cp_addr = a; cp_wdata = d;
    @(negedge clk);
    rd = cp_rdata; dn = cp_done;
    cp_valid = 1'b0;
  endtask

  task automatic host_op(input logic wr, input logic [23:0] a, input logic [7:0] d, output logic [7:0] rd);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    rd = host_rdata;
    host_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  hb;
    logic        dn;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(1, {24'h0, host_rdata}, 32'h0, "host_rdata after reset");
    check(1, {31'h0, cp_done}, 32'h0, "cp_done after reset");
    host_op(1'b0, 24'h3800, 8'h0, hb); check(1, {24'h0, hb}, 32'h0, "c2h0 reset");
    host_op(1'b0, 24'h3802, 8'h0, hb); check(1, {24'h0, hb}, 32'h0, "c2h1 reset");
    host_op(1'b0, 24'h3804, 8'h0, hb); check(1, {24'h0, hb}, 32'h0, "c2h3 reset");
    cp_op(1'b0, 2'd2, 32'h4000_0020, 32'h0, rd, dn); check(1, rd, 32'h0, "h2c0 reset");
    cp_op(1'b0, 2'd0, 32'h4000_002C, 32'h0, rd, dn); check(1, rd, 32'h0, "h2c3 reset");

    // R7 done timing: low before, high one cycle, low after
    @(negedge clk);
    cp_valid = 1'b1; cp_write = 1'b0; cp_size = 2'd2; cp_addr = 32'h0000_0100;
    check(7, {31'h0, cp_done}, 32'h0, "done before accept");
    @(negedge clk);
    cp_valid = 1'b0;
    check(7, {31'h0, cp_done}, 32'h1, "done after accept");
    @(negedge clk);
    check(7, {31'h0, cp_done}, 32'h0, "done one cycle only");

    for (int i = 0; i < NVEC; i++) begin
      case (VEC[i].op)
        OP_CRD: begin
          cp_op(1'b0, VEC[i].size, VEC[i].addr, 32'h0, rd, dn);
          check(int'(VEC[i].req), rd, VEC[i].exp, $sformatf("vec %0d cp read", i));
        end
        OP_CWR: begin
          cp_op(1'b1, VEC[i].size, VEC[i].addr, VEC[i].data, rd, dn);
          check(int'(VEC[i].req), {31'h0, dn}, 32'h1, $sformatf("vec %0d cp write done", i));
        end
        OP_HRD: begin
          host_op(1'b0, VEC[i].addr[23:0], 8'h0, hb);
          check(int'(VEC[i].req), {24'h0, hb}, VEC[i].exp, $sformatf("vec %0d host read", i));
        end
        default: host_op(1'b1, VEC[i].addr[23:0], VEC[i].data[7:0], hb);
      endcase
    end

    // R12 host write and cp read of h2c0 in the same cycle
    @(negedge clk);
    host_valid = 1'b1; host_write = 1'b1; host_addr = 24'h3804; host_wdata = 8'hE1;
    cp_valid = 1'b1; cp_write = 1'b0; cp_size = 2'd0; cp_addr = 32'h4000_0020;
    @(negedge clk);
    host_valid = 1'b0; cp_valid = 1'b0;
    check(12, cp_rdata, 32'h0000_005D, "cp read sees old h2c0");
    cp_op(1'b0, 2'd0, 32'h4000_0020, 32'h0, rd, dn);
    check(12, rd, 32'h0000_00E1, "cp read sees new h2c0");

    // R12 host read of c2h0 in the cycle the cp write commits
    @(negedge clk);
    cp_valid = 1'b1; cp_write = 1'b1; cp_size = 2'd0; cp_addr = 32'h4000_0020; cp_wdata = 32'h3C;
    @(negedge clk);
    cp_valid = 1'b0;
    host_valid = 1'b1; host_write = 1'b0; host_addr = 24'h3800;
    @(negedge clk);
    host_valid = 1'b0;
    check(12, {24'h0, host_rdata}, 32'h78, "host read sees old c2h0");
    host_op(1'b0, 24'h3800, 8'h0, hb);
    check(12, {24'h0, hb}, 32'h3C, "host read sees new c2h0");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule